// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Flow Control

This block is a full-duplex serial channel that moves 8-bit frames against a shared shift clock. As clock master it builds the shift clock from the system clock. A prescaler picks one of four source rates, and an 8-bit divider slows that source further. As clock slave it follows a clock supplied on its clock pin. A holding buffer feeds the transmit shift register. The receive shift register empties into a receive buffer, so software always has one byte of slack on each side.

A single handshake pin can serve as a clear-to-send input or as a ready-to-receive output. The clear-to-send input holds back the start of a frame. The ready output tells a peer that the receive buffer can take a byte. A control bit turns the whole handshake off.

Software sees four 8-bit locations over a simple strobe bus:

| Address | Access | Content |
|---------|--------|---------|
| 0 | read/write | control byte |
| 1 | read/write | divider value n |
| 2 | write | transmit buffer |
| 2 | read | receive buffer |
| 3 | read | status |

Reads are combinational. A read strobe at address 2 also acknowledges the received byte.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status byte reads 0x03 and the control byte reads 0x00, with sck_o=1, txd=1 and sck_oe=1. The status byte carries TI (buffer empty) in bit 0, EPTY (shift register idle) in bit 1, RI (byte received) in bit 2 and OER (overrun) in bit 3.
- R2: In master mode, every low phase and every high phase of sck_o lasts (n+1)·2^s clock cycles, so one bit lasts 2·(n+1)·2^s cycles. Here n is the divider byte and s is the source select in control bits 2:1.
- R3: Control bit 0 picks the clock. With 0 the block drives sck_o and sck_oe=1. With 1, sck_oe=0, and frames are timed only by edges on sck_i, whatever the values of s and n.
- R4: A frame is 8 bits long. Each bit appears on txd after a falling clock edge, and rxd is taken on the rising edge. The clock rests high outside frames.
- R5: Control bit 5 set to 1 shifts the MSB first on both txd and rxd. Set to 0, it shifts the LSB first.
- R6: A frame starts only when control bit 6 (transmit enable) is 1 and the transmit buffer holds a byte. If the handshake is on in clear-to-send direction, hs_i must also be low.
- R7: A write to address 2 fills the buffer and clears TI. Moving the byte into the shift register sets TI. A write while TI is 0 is ignored. EPTY is 1 exactly while no frame is in progress.
- R8: At the end of a frame with control bit 7 (receive enable) at 1 and RI at 0, the byte goes to the receive buffer and RI becomes 1. A read strobe at address 2 clears RI. With receive enable at 0, nothing is stored.
- R9: A frame that ends while RI is 1 sets OER and leaves the receive buffer unchanged. A read strobe at address 2 clears OER.
- R10: With control bit 4 at 0 (handshake on) and control bit 3 at 1 (ready-output direction), hs_oe=1. In that case hs_o is low while receive enable is 1 and RI is 0, and high otherwise. hs_i is then ignored.
- R11: With control bit 4 at 1, hs_oe=0, hs_o=1 and hs_i has no effect on starting frames.
- R12: A byte written while a frame is in progress goes out in the frame that follows, without any further write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | write strobe |
| wr_addr | input | 2 | write address |
| wr_data | input | 8 | write data |
| rd_en | input | 1 | read strobe (acknowledges the receive buffer at address 2) |
| rd_addr | input | 2 | read address |
| rd_data | output | 8 | read data, combinational |
| sck_o | output | 1 | shift clock driven in master mode |
| sck_oe | output | 1 | high when sck_o should drive the clock pin |
| sck_i | input | 1 | shift clock from the pin in slave mode |
| txd | output | 1 | serial data out |
| rxd | input | 1 | serial data in |
| hs_i | input | 1 | clear-to-send input, active low |
| hs_o | output | 1 | ready-to-receive output, active low |
| hs_oe | output | 1 | high when hs_o should drive the handshake pin |

## Verification
The embedded properties assume the following about the inputs:
- Configuration stays unchanged while EPTY is 0.
- In slave mode, sck_i rests high between frames.
- Each sck_i phase lasts several system cycles, so the synchronizer never merges a fall and a rise.
- rxd stays steady from a falling clock edge until past the next rising edge.

The stimulus rewrites the control and divider bytes only after the scoreboard has seen the previous frame complete. It drives the slave clock with eight-cycle phases, and it changes rxd only together with a falling edge. In master mode it loops txd back to rxd, so received data follows transmit timing exactly.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int BUS_W   = 8;
    localparam int FRAME_W = 8;
    localparam int SEL_W   = 2;
    localparam int PRE_W   = (1 << SEL_W) - 1;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_DIV  = 2'd1,
        A_DATA = 2'd2,
        A_STAT = 2'd3
    } addr_e;

    // control byte, bit 7 first
    typedef struct packed {
        logic             rx_en;
        logic             tx_en;
        logic             msb_first;
        logic             hs_off;
        logic             hs_rts;
        logic [SEL_W-1:0] src_sel;
        logic             ext_clk;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       oer;
        logic       ri;
        logic       epty;
        logic       ti;
    } stat_t;

    function automatic logic [PRE_W-1:0] pre_mask(input logic [SEL_W-1:0] sel);
        logic [PRE_W:0] one_hot;
        one_hot = (PRE_W+1)'(1) << sel;
        return PRE_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_clk,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [BUS_W-1:0] div_n,
    input  logic             busy,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             fall_ev,
    output logic             rise_ev
);

    logic [PRE_W-1:0]  pre_cnt;
    logic [BUS_W-1:0]  div_cnt;
    logic              sck_q;
    logic [SYNC_N-1:0] sync_q;
    logic              sck_prev;
    logic              tick;
    logic              div_wrap;
    logic              toggle;
    logic              ext_fall;
    logic              ext_rise;

    assign tick     = (pre_cnt & pre_mask(src_sel)) == pre_mask(src_sel);
    assign div_wrap = (div_cnt == div_n);
    assign toggle   = busy && !ext_clk && tick && div_wrap;

    always_ff @(posedge clk) begin
        if (rst || !busy || ext_clk) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            sck_q   <= 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
            if (tick) begin
                div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
            end
            if (toggle) begin
                sck_q <= !sck_q;
            end
        end
    end

    // external clock: synchronizer and edge detect
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            sck_prev <= 1'b1;
        end else begin
            sync_q   <= {sync_q[SYNC_N-2:0], sck_i};
            sck_prev <= sync_q[SYNC_N-1];
        end
    end

    assign ext_fall = sck_prev && !sync_q[SYNC_N-1];
    assign ext_rise = !sck_prev && sync_q[SYNC_N-1];

    always_comb begin
        if (ext_clk) begin
            fall_ev = busy && ext_fall;
            rise_ev = busy && ext_rise;
        end else begin
            fall_ev = toggle && sck_q;
            rise_ev = toggle && !sck_q;
        end
    end

    assign sck_o = sck_q;

    AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) !busy |-> sck_q); // R4
    AST_ONE_EDGE_KIND: assert property (@(posedge clk) disable iff (rst) !(fall_ev && rise_ev)); // R4
    AST_EXT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst) ext_clk |=> $stable(sck_q)); // R3

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] load_data,
    input  logic               msb_first,
    input  logic               fall_ev,
    input  logic               rise_ev,
    input  logic               rxd,
    output logic               txd,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] rx_data
);

    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] tx_sh;
    logic [FRAME_W-1:0] rx_sh;
    logic [CNT_W-1:0]   bit_cnt;
    logic               busy_q;
    logic               done_q;
    logic               txd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            txd_q   <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q  <= 1'b1;
                tx_sh   <= load_data;
                rx_sh   <= '0;
                bit_cnt <= '0;
            end else if (busy_q) begin
                if (fall_ev) begin
                    if (msb_first) begin
                        txd_q <= tx_sh[FRAME_W-1];
                        tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                    end else begin
                        txd_q <= tx_sh[0];
                        tx_sh <= {1'b0, tx_sh[FRAME_W-1:1]};
                    end
                end
                if (rise_ev) begin
                    if (msb_first) begin
                        rx_sh <= {rx_sh[FRAME_W-2:0], rxd};
                    end else begin
                        rx_sh <= {rxd, rx_sh[FRAME_W-1:1]};
                    end
                    if (bit_cnt == LAST_BIT) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign txd     = txd_q;
    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_data = rx_sh;

    AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst) done_q |-> !busy_q); // R7
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) start |-> !busy_q); // R12
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (rst) start |=> busy_q); // R7

endmodule

// File: rtl/ssp_handshake.sv
module ssp_handshake
    import ssp_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_off,
    input  logic hs_rts,
    input  logic rx_en,
    input  logic ri,
    input  logic hs_i,
    output logic cts_ok,
    output logic hs_o,
    output logic hs_oe
);

    logic [SYNC_N-1:0] cts_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_sync <= '1;
        end else begin
            cts_sync <= {cts_sync[SYNC_N-2:0], hs_i};
        end
    end

    assign cts_ok = hs_off || hs_rts || !cts_sync[SYNC_N-1];
    assign hs_oe  = !hs_off && hs_rts;
    assign hs_o   = hs_oe ? !(rx_en && !ri) : 1'b1;

    AST_RTS_HIGH_WHEN_FULL: assert property (@(posedge clk) disable iff (rst) (hs_oe && ri) |-> hs_o); // R10
    AST_HS_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) hs_off |-> (!hs_oe && hs_o && cts_ok)); // R11

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [BUS_W-1:0] rd_data,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             sck_i,
    output logic             txd,
    input  logic             rxd,
    input  logic             hs_i,
    output logic             hs_o,
    output logic             hs_oe
);

    ctrl_t              ctrl_q;
    logic [BUS_W-1:0]   div_q;
    logic [FRAME_W-1:0] tx_buf;
    logic               tx_full;
    logic [FRAME_W-1:0] rx_buf;
    logic               ri_q;
    logic               oer_q;

    logic               busy;
    logic               done;
    logic [FRAME_W-1:0] rx_data;
    logic               fall_ev;
    logic               rise_ev;
    logic               cts_ok;
    logic               start;
    logic               rx_read;
    stat_t              stat;

    assign start   = ctrl_q.tx_en && tx_full && cts_ok && !busy;
    assign rx_read = rd_en && (addr_e'(rd_addr) == A_DATA);

    // configuration and transmit buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            div_q   <= '0;
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else begin
            if (start) begin
                tx_full <= 1'b0;
            end
            if (wr_en) begin
                case (addr_e'(wr_addr))
                    A_CTRL: ctrl_q <= ctrl_t'(wr_data);
                    A_DIV:  div_q  <= wr_data;
                    A_DATA: begin
                        if (!tx_full) begin
                            tx_buf  <= wr_data;
                            tx_full <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // receive buffer and its flags
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_buf <= '0;
            ri_q   <= 1'b0;
            oer_q  <= 1'b0;
        end else begin
            if (rx_read) begin
                ri_q  <= 1'b0;
                oer_q <= 1'b0;
            end
            if (done && ctrl_q.rx_en) begin
                if (ri_q && !rx_read) begin
                    oer_q <= 1'b1;
                end else begin
                    rx_buf <= rx_data;
                    ri_q   <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        stat      = '0;
        stat.ti   = !tx_full;
        stat.epty = !busy;
        stat.ri   = ri_q;
        stat.oer  = oer_q;
    end

    always_comb begin
        case (addr_e'(rd_addr))
            A_CTRL:  rd_data = ctrl_q;
            A_DIV:   rd_data = div_q;
            A_DATA:  rd_data = rx_buf;
            default: rd_data = stat;
        endcase
    end

    ssp_clkgen #(.SYNC_N(SYNC_N)) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .ext_clk (ctrl_q.ext_clk),
        .src_sel (ctrl_q.src_sel),
        .div_n   (div_q),
        .busy    (busy),
        .sck_i   (sck_i),
        .sck_o   (sck_o),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev)
    );

    ssp_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load_data (tx_buf),
        .msb_first (ctrl_q.msb_first),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .rxd       (rxd),
        .txd       (txd),
        .busy      (busy),
        .done      (done),
        .rx_data   (rx_data)
    );

    ssp_handshake #(.SYNC_N(SYNC_N)) u_handshake (
        .clk    (clk),
        .rst    (rst),
        .hs_off (ctrl_q.hs_off),
        .hs_rts (ctrl_q.hs_rts),
        .rx_en  (ctrl_q.rx_en),
        .ri     (ri_q),
        .hs_i   (hs_i),
        .cts_ok (cts_ok),
        .hs_o   (hs_o),
        .hs_oe  (hs_oe)
    );

    assign sck_oe = !ctrl_q.ext_clk;

    AST_OER_IMPLIES_RI: assert property (@(posedge clk) disable iff (rst) oer_q |-> ri_q); // R9
    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && ctrl_q.rx_en && ri_q && !rx_read) |=> (oer_q && $stable(rx_buf))); // R9
    AST_TI_AFTER_START: assert property (@(posedge clk) disable iff (rst) start |=> !tx_full); // R7
    AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (rst) (!cts_ok && !busy) |=> !busy); // R6
    AST_TE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst) (!ctrl_q.tx_en && !busy) |=> !busy); // R6
    AST_NO_RX_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.rx_en && !ri_q) |=> !ri_q); // R8

endmodule

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd3;
    logic [7:0] rd_data;
    logic       sck_o, sck_oe, txd, hs_o, hs_oe;
    logic       sck_drv = 1'b1;
    logic       rxd_drv = 1'b1;
    logic       hs_drv = 1'b1;
    logic       loop = 1'b0;
    logic       ext_mode = 1'b0;
    logic       rxd;

    int total = 0;
    int bad = 0;
    int frames_seen = 0;
    int last_low = 0;
    int last_period = 0;
    logic [7:0] exp_q[$];

    always #4 clk = !clk;

    assign rxd = loop ? txd : rxd_drv;

    sync_serial_port uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_drv), .txd(txd), .rxd(rxd),
        .hs_i(hs_drv), .hs_o(hs_o), .hs_oe(hs_oe)
    );

    function automatic logic [7:0] flip(input logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = d[7-i];
        return r;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 2'd3;
    endtask

    // driver: queue the expected wire byte, then fill the buffer
    task automatic send(input logic [7:0] d, input logic msb);
        exp_q.push_back(msb ? d : flip(d));
        write_reg(2'd2, d);
    endtask

    task automatic wait_frames(input int target);
        while (frames_seen < target) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic ext_frame(input logic [7:0] b, input logic msb);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #1 sck_drv = 1'b0;
            rxd_drv = msb ? b[7-i] : b[i];
            repeat (8) @(negedge clk);
            #1 sck_drv = 1'b1;
            repeat (8) @(negedge clk);
        end
    endtask

    // monitor: collects wire bits on rising clock, compares with the queue, times phases
    logic       sck_last = 1'b1;
    logic [7:0] mon_bits = '0;
    int         mon_n = 0;
    int         low_cnt = 0;
    int         per_cnt = 0;
    always @(negedge clk) begin
        logic sck_now;
        sck_now = ext_mode ? sck_drv : sck_o;
        if (!rst) begin
            per_cnt++;
            if (sck_last && !sck_now) low_cnt = 1;
            else if (!sck_now) low_cnt++;
            if (sck_now && !sck_last) begin
                mon_bits = {mon_bits[6:0], txd};
                mon_n++;
                last_low = low_cnt;
                last_period = per_cnt;
                per_cnt = 0;
                if (mon_n == 8) begin
                    mon_n = 0;
                    frames_seen++;
                    if (exp_q.size() == 0) begin
                        check("R4", "unexpected frame", {24'd0, mon_bits}, 32'hFFFF_FFFF);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check("R4 R5", "wire frame order", {24'd0, mon_bits}, {24'd0, e});
                    end
                end
            end
        end
        sck_last = sck_now;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_reg(2'd3, d); check("R1", "status", d, 8'h03);
        read_reg(2'd0, d); check("R1", "control", d, 8'h00);
        check("R1", "sck_o", sck_o, 1); check("R1", "txd", txd, 1);
        check("R3", "sck_oe master", sck_oe, 1);

        // master loopback, MSB first, s=1 n=2
        loop = 1'b1;
        write_reg(2'd1, 8'd2);
        write_reg(2'd0, 8'hF2);
        send(8'hA5, 1'b1);
        wait_frames(1);
        check("R2", "low phase s1 n2", last_low, 6);
        check("R2", "bit period s1 n2", last_period, 12);
        read_reg(2'd3, d); check("R8", "status after rx", d, 8'h07);
        read_reg(2'd2, d); check("R8", "rx byte", d, 8'hA5);
        read_reg(2'd3, d); check("R8", "RI cleared by read", d, 8'h03);

        // R9 overrun
        send(8'h3C, 1'b1); wait_frames(2);
        send(8'hC3, 1'b1); wait_frames(3);
        read_reg(2'd3, d); check("R9", "overrun status", d, 8'h0F);
        read_reg(2'd2, d); check("R9", "buffer kept first byte", d, 8'h3C);
        read_reg(2'd3, d); check("R9", "OER cleared", d, 8'h03);

        // R5 LSB first, s=0 n=0
        write_reg(2'd1, 8'd0);
        write_reg(2'd0, 8'hD0);
        send(8'h96, 1'b0); wait_frames(4);
        check("R2", "low phase s0 n0", last_low, 1);
        check("R2", "bit period s0 n0", last_period, 2);
        read_reg(2'd2, d); check("R5", "lsb-first rx byte", d, 8'h96);

        // R12 double buffer, R7 write while full, R8 receive off
        write_reg(2'd1, 8'd3);
        write_reg(2'd0, 8'h70);
        send(8'h11, 1'b1);
        d = 8'h00;
        while (d[0] == 1'b0) read_reg(2'd3, d);
        send(8'h22, 1'b1);
        read_reg(2'd3, d); check("R12", "buffer full while busy", {30'd0, d[1:0]}, 0);
        write_reg(2'd2, 8'h33);
        wait_frames(6);
        repeat (60) @(negedge clk);
        check("R7", "write while full ignored", frames_seen, 6);
        read_reg(2'd3, d); check("R8", "receive off stores nothing", d, 8'h03);

        // R6 transmit enable off
        write_reg(2'd0, 8'hB0);
        write_reg(2'd2, 8'h44);
        repeat (60) @(negedge clk);
        read_reg(2'd3, d); check("R6", "TE off holds buffer", d, 8'h02);
        check("R6", "TE off no frame", frames_seen, 6);
        exp_q.push_back(8'h44);
        write_reg(2'd0, 8'hF0);
        wait_frames(7);
        read_reg(2'd2, d); check("R6", "byte after TE on", d, 8'h44);

        // R6 clear-to-send gating
        hs_drv = 1'b1;
        write_reg(2'd0, 8'hE0);
        send(8'h5A, 1'b1);
        repeat (60) @(negedge clk);
        read_reg(2'd3, d); check("R6", "CTS high blocks", d, 8'h02);
        hs_drv = 1'b0;
        wait_frames(8);
        read_reg(2'd2, d); check("R6", "byte after CTS low", d, 8'h5A);

        // R10 ready output
        hs_drv = 1'b1;
        write_reg(2'd0, 8'hE8);
        check("R10", "hs_oe in RTS dir", hs_oe, 1);
        check("R10", "RTS low when ready", hs_o, 0);
        send(8'h77, 1'b1); wait_frames(9);
        check("R10", "RTS high with RI", hs_o, 1);
        read_reg(2'd2, d); check("R10", "rx byte ignoring hs_i", d, 8'h77);
        @(negedge clk);
        check("R10", "RTS low after read", hs_o, 0);
        write_reg(2'd0, 8'h68);
        check("R10", "RTS high with RE off", hs_o, 1);

        // R11 handshake off
        write_reg(2'd0, 8'hF0);
        check("R11", "hs_oe off", hs_oe, 0);
        check("R11", "hs_o idle", hs_o, 1);
        send(8'h99, 1'b1); wait_frames(10);
        read_reg(2'd2, d); check("R11", "frame despite hs_i high", d, 8'h99);

        // R3 slave mode, MSB first, s and n set slow but ignored
        loop = 1'b0;
        write_reg(2'd1, 8'd255);
        write_reg(2'd0, 8'hF7);
        ext_mode = 1'b1;
        check("R3", "sck_oe slave", sck_oe, 0);
        send(8'hE1, 1'b1);
        repeat (6) @(negedge clk);
        base = frames_seen;
        ext_frame(8'h4B, 1'b1);
        repeat (8) @(negedge clk);
        check("R3", "slave frame seen", frames_seen, base + 1);
        read_reg(2'd2, d); check("R3", "slave rx byte", d, 8'h4B);
        check("R3", "sck_o idle in slave", sck_o, 1);

        // R5 slave LSB first
        write_reg(2'd0, 8'hD7);
        send(8'h0F, 1'b0);
        repeat (6) @(negedge clk);
        ext_frame(8'hB2, 1'b0);
        repeat (8) @(negedge clk);
        read_reg(2'd2, d); check("R5", "slave lsb-first rx", d, 8'hB2);
        check("R4", "scoreboard drained", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule